// File: doc/BRIEF.md
# Gatable Astable and Retriggerable One-Shot Pulse Generator

This block is a fully clocked pulse generator that serves both as a free-running square-wave source and as an edge-triggered one-shot. A programmable cycle counter replaces the analog timing network. The counter runs through a sequence of timing periods. The first period after any start uses one length, and every later period uses a second length. A toggle stage turns these periods into the complementary outputs `q_o` and `q_n_o`. A secondary oscillator output runs once per timing period, so its rate is twice that of `q_o`.

In astable use, a level on either of two gate inputs of opposite polarity keeps the generator running. An external countdown counter can drive one of these gates to build long one-shot pulses. In monostable use, a positive trigger edge or a negative trigger edge starts a pulse that lasts one first-period length. Pulses started through the positive path or the retrigger input stretch by whole normal periods for as long as the retrigger level stays high. An external reset level ends any activity at once and holds the outputs idle. All control inputs are asynchronous and are synchronized inside the block. The two lengths are given in clock cycles.

Top module: `pulse_multivib`

## Requirements
- R1: After `rst_n` is released, `q_o`=0, `q_n_o`=1 and `osc_o`=0. `osc_o` is 0 whenever the generator is idle.
- R2: Astable running is enabled while `gate_hi_i`=1 or `gate_lo_n_i`=0. When neither condition holds, a running astable stops and `q_o` goes to 0.
- R3: In astable running, `q_n_o` is always the complement of `q_o`. `q_o` first stays high for the first-period length. It then alternates low and high, each phase lasting the normal length.
- R4: While running, `osc_o` is high for the first ceil(L/2) cycles of each timing period of length L and low for the rest of that period.
- R5: A one-shot starts when `trig_pos_i` rises while `trig_neg_i` is 0, or when `trig_neg_i` falls while `trig_pos_i` is 1. A rise of `trig_pos_i` while `trig_neg_i` is 1 starts nothing.
- R6: The width of a one-shot pulse is the first-period length, however long the trigger is held. Trigger edges that arrive during a pulse are ignored.
- R7: A rising edge of `retrig_i` while idle also starts a pulse. For a pulse started this way or by `trig_pos_i`, each period end at which the synchronized `retrig_i` is still 1 adds one normal period. The width is therefore the first length plus a whole number of normal lengths.
- R8: A pulse started by the falling edge of `trig_neg_i` is never extended by `retrig_i`.
- R9: `ext_rst_i`=1 drives `q_o` low and `q_n_o` high, ends any pulse or astable run, and blocks all starts while it is held.
- R10: A length input of 0 is treated as 1. Each length input is sampled when a period of that kind begins.
- R11: Every control input affects the outputs at the third rising clock edge, counting the first edge that samples the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gate_hi_i | input | 1 | Astable enable, active high |
| gate_lo_n_i | input | 1 | Astable enable, active low |
| trig_pos_i | input | 1 | Rising-edge trigger |
| trig_neg_i | input | 1 | Falling-edge trigger |
| retrig_i | input | 1 | Retrigger level and start edge |
| ext_rst_i | input | 1 | External reset, active high |
| first_len_i | input | CNT_W | First timing period length in cycles |
| norm_len_i | input | CNT_W | Normal timing period length in cycles |
| q_o | output | 1 | Main output |
| q_n_o | output | 1 | Complement of main output |
| osc_o | output | 1 | Oscillator output, one cycle per timing period |

## Verification
Astable running is driven through each gate polarity in turn. This separates the OR of the two enables, and the measured first high phase is distinct from the later normal phases. One-shots are fired by a long-held positive trigger, by a one-cycle positive trigger, and by the negative path, with a positive edge under a high negative trigger as a non-start. This tells width independence apart from edge qualification. The retrigger is held for 20, 21 and 50 cycles against lengths 20 and 16, which puts the extension decision exactly at a period boundary. It is also held across a negative-path pulse to show that no extension occurs. Zero lengths, an external reset in mid-pulse and a gate asserted under reset cover the clamps and blocking paths.

// File: rtl/mv_pkg.sv
package mv_pkg;
  typedef enum logic [1:0] {
    MV_IDLE  = 2'd0,
    MV_ASTAB = 2'd1,
    MV_MONO  = 2'd2
  } mv_mode_e;

  localparam int MV_NIN     = 6;
  localparam int IX_GATE_HI = 0;
  localparam int IX_GATE_LN = 1;
  localparam int IX_TRIG_P  = 2;
  localparam int IX_TRIG_N  = 3;
  localparam int IX_RETRIG  = 4;
  localparam int IX_KILL    = 5;

  localparam logic [MV_NIN-1:0] MV_IN_RST = 6'b000010;
endpackage

// File: rtl/mv_rst_sync.sv
module mv_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic r1_q;
  logic r2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r1_q <= 1'b0;
      r2_q <= 1'b0;
    end else begin
      r1_q <= 1'b1;
      r2_q <= r1_q;
    end
  end

  assign rst_sync_n = r2_q;
endmodule

// File: rtl/mv_in_sync.sv
module mv_in_sync #(
  parameter int                N       = 6,
  parameter logic [N-1:0]      RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] prv_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic meta_q;
    logic lvl_q;
    logic prv_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= RST_VAL[i];
        lvl_q  <= RST_VAL[i];
        prv_q  <= RST_VAL[i];
      end else begin
        meta_q <= async_i[i];
        lvl_q  <= meta_q;
        prv_q  <= lvl_q;
      end
    end

    assign lvl_o[i] = lvl_q;
    assign prv_o[i] = prv_q;
  end
endmodule

// File: rtl/mv_period_timer.sv
module mv_period_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_i,
  input  logic         start_i,
  input  logic [W-1:0] first_i,
  input  logic [W-1:0] norm_i,
  output logic         end_o,
  output logic         osc_o,
  output logic [W-1:0] len_o
);
  localparam logic [W-1:0] ONE  = W'(1);
  localparam logic [W:0]   ONEX = (W+1)'(1);

  logic [W-1:0] cnt_q, cnt_d;
  logic [W-1:0] len_q, len_d;
  logic [W-1:0] first_eff, norm_eff;
  logic [W:0]   half_up;
  logic         last;
  logic         tick_en;

  assign first_eff = (first_i == '0) ? ONE : first_i;
  assign norm_eff  = (norm_i == '0) ? ONE : norm_i;
  assign last      = (cnt_q == (len_q - ONE));
  assign tick_en   = start_i | run_i;
  assign half_up   = ({1'b0, len_q} + ONEX) >> 1;

  always_comb begin
    cnt_d = cnt_q;
    len_d = len_q;
    if (start_i) begin
      cnt_d = '0;
      len_d = first_eff;
    end else if (run_i) begin
      if (last) begin
        cnt_d = '0;
        len_d = norm_eff;
      end else begin
        cnt_d = cnt_q + ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      len_q <= ONE;
    end else if (tick_en) begin
      cnt_q <= cnt_d;
      len_q <= len_d;
    end
  end

  assign end_o = run_i & last;
  assign osc_o = run_i & ({1'b0, cnt_q} < half_up);
  assign len_o = len_q;
endmodule

// File: rtl/mv_mode_ctrl.sv
module mv_mode_ctrl
  import mv_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     gate_i,
  input  logic     pos_ev_i,
  input  logic     neg_ev_i,
  input  logic     rtg_rise_i,
  input  logic     rtg_lvl_i,
  input  logic     kill_i,
  input  logic     tmr_end_i,
  output mv_mode_e mode_o,
  output logic     q_o,
  output logic     q_n_o,
  output logic     start_o,
  output logic     rtg_ok_o
);
  mv_mode_e mode_q, mode_d;
  logic     q_q, q_d;
  logic     qn_q;
  logic     ok_q, ok_d;

  always_comb begin
    mode_d  = mode_q;
    q_d     = q_q;
    ok_d    = ok_q;
    start_o = 1'b0;
    if (kill_i) begin
      mode_d = MV_IDLE;
      q_d    = 1'b0;
    end else if (gate_i && (mode_q != MV_ASTAB)) begin
      mode_d  = MV_ASTAB;
      q_d     = 1'b1;
      start_o = 1'b1;
    end else begin
      case (mode_q)
        MV_ASTAB: begin
          if (!gate_i) begin
            mode_d = MV_IDLE;
            q_d    = 1'b0;
          end else if (tmr_end_i) begin
            q_d = ~q_q;
          end
        end
        MV_MONO: begin
          if (tmr_end_i && !(ok_q && rtg_lvl_i)) begin
            mode_d = MV_IDLE;
            q_d    = 1'b0;
          end
        end
        default: begin
          if (pos_ev_i || neg_ev_i || rtg_rise_i) begin
            mode_d  = MV_MONO;
            q_d     = 1'b1;
            start_o = 1'b1;
            ok_d    = pos_ev_i | rtg_rise_i;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MV_IDLE;
      q_q    <= 1'b0;
      qn_q   <= 1'b1;
      ok_q   <= 1'b0;
    end else begin
      mode_q <= mode_d;
      q_q    <= q_d;
      qn_q   <= ~q_d;
      ok_q   <= ok_d;
    end
  end

  assign mode_o   = mode_q;
  assign q_o      = q_q;
  assign q_n_o    = qn_q;
  assign rtg_ok_o = ok_q;
endmodule

// File: rtl/pulse_multivib.sv
module pulse_multivib
  import mv_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gate_hi_i,
  input  logic             gate_lo_n_i,
  input  logic             trig_pos_i,
  input  logic             trig_neg_i,
  input  logic             retrig_i,
  input  logic             ext_rst_i,
  input  logic [CNT_W-1:0] first_len_i,
  input  logic [CNT_W-1:0] norm_len_i,
  output logic             q_o,
  output logic             q_n_o,
  output logic             osc_o
);
  logic              rst_int_n;
  logic [MV_NIN-1:0] raw_in;
  logic [MV_NIN-1:0] lvl;
  logic [MV_NIN-1:0] prv;
  logic              gate_on;
  logic              pos_ev;
  logic              neg_ev;
  logic              rtg_rise;
  logic              kill;
  logic              trig_any;
  logic              tmr_start;
  logic              tmr_end;
  logic              tmr_run;
  logic              rtg_ok;
  logic [CNT_W-1:0]  cur_len;
  mv_mode_e          mode;
  logic              unused_prev;

  assign raw_in[IX_GATE_HI] = gate_hi_i;
  assign raw_in[IX_GATE_LN] = gate_lo_n_i;
  assign raw_in[IX_TRIG_P]  = trig_pos_i;
  assign raw_in[IX_TRIG_N]  = trig_neg_i;
  assign raw_in[IX_RETRIG]  = retrig_i;
  assign raw_in[IX_KILL]    = ext_rst_i;

  mv_rst_sync u_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_int_n)
  );

  mv_in_sync #(
    .N      (MV_NIN),
    .RST_VAL(MV_IN_RST)
  ) u_in_sync (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .async_i(raw_in),
    .lvl_o  (lvl),
    .prv_o  (prv)
  );

  assign gate_on  = lvl[IX_GATE_HI] | ~lvl[IX_GATE_LN];
  assign pos_ev   = lvl[IX_TRIG_P] & ~prv[IX_TRIG_P] & ~lvl[IX_TRIG_N];
  assign neg_ev   = ~lvl[IX_TRIG_N] & prv[IX_TRIG_N] & lvl[IX_TRIG_P];
  assign rtg_rise = lvl[IX_RETRIG] & ~prv[IX_RETRIG];
  assign kill     = lvl[IX_KILL];
  assign trig_any = pos_ev | neg_ev | rtg_rise;
  assign tmr_run  = (mode != MV_IDLE);
  assign unused_prev = prv[IX_GATE_HI] ^ prv[IX_GATE_LN] ^ prv[IX_KILL];

  mv_period_timer #(
    .W(CNT_W)
  ) u_timer (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .run_i  (tmr_run),
    .start_i(tmr_start),
    .first_i(first_len_i),
    .norm_i (norm_len_i),
    .end_o  (tmr_end),
    .osc_o  (osc_o),
    .len_o  (cur_len)
  );

  mv_mode_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .gate_i    (gate_on),
    .pos_ev_i  (pos_ev),
    .neg_ev_i  (neg_ev),
    .rtg_rise_i(rtg_rise),
    .rtg_lvl_i (lvl[IX_RETRIG]),
    .kill_i    (kill),
    .tmr_end_i (tmr_end),
    .mode_o    (mode),
    .q_o       (q_o),
    .q_n_o     (q_n_o),
    .start_o   (tmr_start),
    .rtg_ok_o  (rtg_ok)
  );
endmodule

// File: rtl/mv_checker.sv
module mv_checker
  import mv_pkg::*;
#(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         q,
  input logic         q_n,
  input logic         osc,
  input mv_mode_e     mode,
  input logic         gate,
  input logic         kill,
  input logic         trig_any,
  input logic         tmr_end,
  input logic         rtg_ok,
  input logic         rtg_lvl,
  input logic [W-1:0] cur_len
);
  AST_Q_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
    q_n == ~q); // R3

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MV_IDLE) |-> (!q && !osc)); // R1

  AST_KILL_FORCES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    kill |=> (!q && q_n && mode == MV_IDLE)); // R9

  AST_GATE_DROP_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MV_ASTAB && !gate && !kill) |=> !q); // R2

  AST_LEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cur_len != '0); // R10

  AST_TRIG_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MV_IDLE && trig_any && !kill) |=> q); // R5

  AST_RETRIG_EXTENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MV_MONO && tmr_end && rtg_ok && rtg_lvl && !gate && !kill) |=> (q && mode == MV_MONO)); // R7

  AST_NO_EXTEND_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MV_MONO && tmr_end && !rtg_ok && !gate && !kill) |=> (mode == MV_IDLE)); // R8
endmodule

bind pulse_multivib mv_checker #(.W(CNT_W)) u_mv_chk (
  .clk     (clk),
  .rst_n   (rst_int_n),
  .q       (q_o),
  .q_n     (q_n_o),
  .osc     (osc_o),
  .mode    (mode),
  .gate    (gate_on),
  .kill    (kill),
  .trig_any(trig_any),
  .tmr_end (tmr_end),
  .rtg_ok  (rtg_ok),
  .rtg_lvl (lvl[mv_pkg::IX_RETRIG]),
  .cur_len (cur_len)
);

// File: tb/test_pulse_multivib.sv
module test_pulse_multivib;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         gh, gln, tp, tn, rt, er;
  logic [W-1:0] first_len, norm_len;
  logic         q_o, q_n_o, osc_o;

  int    n_chk  = 0;
  int    n_fail = 0;
  string tag    = "R1";
  bit    chk_on = 1'b0;

  always #4 clk = ~clk;

  pulse_multivib #(.CNT_W(W)) i_pulse_multivib (
    .clk(clk), .rst_n(rst_n),
    .gate_hi_i(gh), .gate_lo_n_i(gln),
    .trig_pos_i(tp), .trig_neg_i(tn),
    .retrig_i(rt), .ext_rst_i(er),
    .first_len_i(first_len), .norm_len_i(norm_len),
    .q_o(q_o), .q_n_o(q_n_o), .osc_o(osc_o)
  );

  // Behavioural reference: input history queue, mode 0 idle / 1 astable / 2 one-shot
  logic [5:0] hist[$];
  int mst, mcnt, mlen;
  bit mq, mok, mosc;

  function automatic int clampv(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = {6'b000010, 6'b000010, 6'b000010, 6'b000010};
      mst = 0; mcnt = 0; mlen = 1; mq = 0; mok = 0;
    end else begin
      logic [5:0] cur, prv;
      bit gate, trp, trn, rre, rlv, kil, mend;
      hist.push_front({er, rt, tn, tp, gln, gh});
      void'(hist.pop_back());
      cur  = hist[2];
      prv  = hist[3];
      gate = cur[0] | ~cur[1];
      trp  = cur[2] & ~prv[2] & ~cur[3];
      trn  = ~cur[3] & prv[3] & cur[2];
      rre  = cur[4] & ~prv[4];
      rlv  = cur[4];
      kil  = cur[5];
      mend = (mst != 0) && (mcnt == mlen - 1);
      if (kil) begin
        mst = 0; mq = 0;
      end else if (gate && mst != 1) begin
        mst = 1; mq = 1; mcnt = 0; mlen = clampv(int'(first_len));
      end else if (mst == 1) begin
        if (!gate) begin
          mst = 0; mq = 0;
        end else if (mend) begin
          mq = !mq; mcnt = 0; mlen = clampv(int'(norm_len));
        end else mcnt++;
      end else if (mst == 2) begin
        if (mend) begin
          if (mok && rlv) begin
            mcnt = 0; mlen = clampv(int'(norm_len));
          end else begin
            mst = 0; mq = 0;
          end
        end else mcnt++;
      end else if (trp || trn || rre) begin
        mst = 2; mq = 1; mcnt = 0; mlen = clampv(int'(first_len)); mok = trp | rre;
      end
    end
    mosc = (mst != 0) && (mcnt < (mlen + 1) / 2);
  end

  always @(negedge clk) begin
    if (rst_n && chk_on) begin
      n_chk++;
      if (q_o !== mq || q_n_o !== !mq) begin
        n_fail++;
        $display("FAIL %s (ref) q=%b q_n=%b expected q=%b q_n=%b", tag, q_o, q_n_o, mq, !mq);
      end
      if (osc_o !== mosc) begin
        n_fail++;
        $display("FAIL R4 (ref, %s) osc=%b expected %b", tag, osc_o, mosc);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic meas(input bit lvl, output int w);
    int guard = 0;
    w = 0;
    while (q_o !== lvl && guard < 400) begin
      @(negedge clk);
      guard++;
    end
    while (q_o === lvl && w < 2000) begin
      @(negedge clk);
      w++;
    end
  endtask

  task automatic count_high(input int n, output int h);
    h = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (q_o === 1'b1) h++;
    end
  endtask

  task automatic pulse_tp();
    tp = 1'b1; cyc(1); tp = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    int w, h;
    gh = 0; gln = 1; tp = 0; tn = 0; rt = 0; er = 0;
    first_len = 16'd20; norm_len = 16'd16;
    rst_n = 1'b0;
    cyc(4);
    rst_n = 1'b1;
    cyc(6);
    // R1 reset state
    chk("R1", q_o, 0, "q after reset");
    chk("R1", q_n_o, 1, "q_n after reset");
    chk("R1", osc_o, 0, "osc after reset");
    chk_on = 1'b1;

    // R3 astable through the active-high gate
    tag = "R3";
    gh = 1;
    meas(1, w); chk("R3", w, 20, "first high phase");
    meas(0, w); chk("R3", w, 16, "normal low phase");
    meas(1, w); chk("R3", w, 16, "normal high phase");
    tag = "R2";
    gh = 0; cyc(3);
    chk("R2", q_o, 0, "q after gate drop");
    cyc(10);

    // R2 active-low gate
    gln = 0;
    meas(1, w); chk("R2", w, 20, "first high via low gate");
    gln = 1; cyc(10);
    chk("R2", q_o, 0, "q with both gates idle");
    count_high(30, h); chk("R2", h, 0, "high cycles with gates idle");

    // R11 input latency
    tag = "R11";
    gh = 1; cyc(2);
    chk("R11", q_o, 0, "q two edges after gate");
    cyc(1);
    chk("R11", q_o, 1, "q three edges after gate");
    gh = 0; cyc(10);

    // R4 oscillator within periods
    tag = "R4";
    first_len = 16'd6; norm_len = 16'd5;
    gh = 1;
    meas(1, w); chk("R4", w, 6, "first period with length 6");
    chk("R4", osc_o, 1, "osc at period cycle 0");
    cyc(2); chk("R4", osc_o, 1, "osc at period cycle 2");
    cyc(1); chk("R4", osc_o, 0, "osc at period cycle 3");
    gh = 0; cyc(10);
    first_len = 16'd20; norm_len = 16'd16;

    // R6 width independent of trigger duration
    tag = "R6";
    fork
      meas(1, w);
      begin tp = 1; cyc(50); tp = 0; end
    join
    chk("R6", w, 20, "width with long trigger");
    cyc(10);
    tag = "R5";
    fork
      meas(1, w);
      pulse_tp();
    join
    chk("R5", w, 20, "width with one-cycle trigger");
    cyc(10);
    tag = "R6";
    fork
      meas(1, w);
      begin pulse_tp(); cyc(8); pulse_tp(); end
    join
    chk("R6", w, 20, "second trigger in pulse ignored");
    count_high(20, h); chk("R6", h, 0, "no pulse after ignored trigger");

    // R5 negative path and a blocked positive edge
    tag = "R5";
    tn = 1; cyc(3); tp = 1; cyc(10);
    chk("R5", q_o, 0, "positive edge under high negative trigger");
    fork
      meas(1, w);
      begin tn = 0; cyc(2); end
    join
    chk("R5", w, 20, "negative-edge one-shot width");
    tp = 0; cyc(10);

    // R7 retrigger boundaries
    tag = "R7";
    fork meas(1, w); begin rt = 1; cyc(50); rt = 0; end join
    chk("R7", w, 52, "retrigger held 50");
    cyc(10);
    fork meas(1, w); begin rt = 1; cyc(21); rt = 0; end join
    chk("R7", w, 36, "retrigger held 21");
    cyc(10);
    fork meas(1, w); begin rt = 1; cyc(20); rt = 0; end join
    chk("R7", w, 20, "retrigger held 20");
    cyc(10);

    // R8 negative-path pulse is not extended
    tag = "R8";
    fork
      meas(1, w);
      begin tn = 1; cyc(3); tp = 1; cyc(3); tn = 0; cyc(5); rt = 1; cyc(40); rt = 0; end
    join
    chk("R8", w, 20, "negative-path pulse with retrigger held");
    tp = 0; cyc(10);

    // R9 external reset
    tag = "R9";
    fork
      meas(1, w);
      begin pulse_tp(); cyc(7); er = 1; end
    join
    chk("R9", w, 8, "pulse cut by external reset");
    chk("R9", q_n_o, 1, "q_n under external reset");
    fork
      count_high(30, h);
      begin pulse_tp(); cyc(3); gh = 1; end
    join
    chk("R9", h, 0, "starts blocked under external reset");
    gh = 0; er = 0; cyc(8);
    fork meas(1, w); pulse_tp(); join
    chk("R9", w, 20, "one-shot after reset release");
    cyc(10);

    // R10 zero lengths
    tag = "R10";
    first_len = 16'd0; norm_len = 16'd0;
    gh = 1;
    meas(1, w); chk("R10", w, 1, "high phase with zero length");
    meas(0, w); chk("R10", w, 1, "low phase with zero length");
    gh = 0; cyc(6);
    norm_len = 16'd5;
    fork meas(1, w); pulse_tp(); join
    chk("R10", w, 1, "one-shot with zero first length");
    cyc(10);

    chk_on = 1'b0;
    summary();
    $finish;
  end
endmodule